// File: doc/BRIEF.md
# No-Turnaround Pipelined Burst SRAM

This block is a synthesizable model of a synchronous burst SRAM whose bus needs no idle cycle between reads and writes. A host issues one command per enabled clock edge. A command is either a load, which starts a new read or write at a given address, or an advance, which moves to the next beat of the burst already open. Read data and write data both use the shared 36-bit bus in the same slot: the slot two enabled edges after their command. Reads and writes can therefore follow each other on every cycle with no idle slot between them.

The data word is split into four 9-bit lanes, and each lane has its own write mask. The two low address bits of a burst follow either interleaved or linear order, set by a static select pin. An asynchronous output enable gates the bus drivers. An asynchronous sleep input floats the bus, ignores every other input, drops in-flight work and keeps the memory contents. After sleep is released, a recovery window of a set number of enabled edges accepts no writes. Depth, lane count, lane width and the recovery length are parameters.

Top module: `nt_burst_sram`

## Requirements
- R1: While `rstN` is low and after its release, no operation is pending and the bus is not driven by the block until a read reaches it.
- R2: A load cycle (`advLoad`=0) with the chip selected and `readNotWrite`=1 drives the word at `addr` onto `dataBus` after the next enabled edge, for the host to capture at the second enabled edge after the command.
- R3: A load with `readNotWrite`=0 writes the value on `dataBus` at the second enabled edge after the command. Bit i of `byteWeN` (active low, sampled with the command or burst beat) gates lane i, which is bits [9i+8:9i]. Masked lanes keep their old value.
- R4: An advance cycle (`advLoad`=1) ignores the chip enables and `readNotWrite`. It repeats the open command on the next beat, keeping the upper address bits. With `burstInterleave`=1 the low two bits are the start bits XOR the beat count.
- R5: With `burstInterleave`=0 the low two bits are the start bits plus the beat count modulo 4, so a burst wraps after four beats and keeps going on further advances.
- R6: While `clkEnN` is high, clock edges have no effect: the bus keeps its read data and no address or command is taken.
- R7: With `outEnN` high the block never drives `dataBus`, even while read data is valid. The effect is immediate and not tied to the clock.
- R8: A load cycle in which the chip is not selected (selection needs `ceN0`=0, `ce1`=1, `ceN2`=0) ends any burst. Later advances then do nothing, and the bus floats once the last read has left it.
- R9: A read of an address written by the command just before it returns the newly written lanes merged with the old unmasked lanes.
- R10: While `sleep` is high the bus floats at once, every other input is ignored, in-flight operations are dropped, and the memory contents are kept.
- R11: For `WAKE_CYCLES` enabled edges after `sleep` falls, write loads are discarded and treated as deselects, while reads complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins except `outEnN` and `sleep` act on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of the pipeline (memory not cleared) |
| clkEnN | input | 1 | Active-low clock enable; high masks the edge |
| addr | input | ADDR_W | Word address, taken on a selected load |
| ceN0 | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ceN2 | input | 1 | Chip enable, active low |
| advLoad | input | 1 | 0 = load a new command, 1 = advance the open burst |
| readNotWrite | input | 1 | On a load: 1 = read, 0 = write |
| byteWeN | input | LANES | Active-low per-lane write enables |
| outEnN | input | 1 | Asynchronous active-low output enable |
| burstInterleave | input | 1 | Static burst order: 1 interleaved (tie high if unused), 0 linear |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dataBus | inout | LANES*LANE_W | Shared read/write data bus |

## Verification
Two functions meet in one edge when a write commits its bus data to the array at the same enabled edge at which the next command, a read of that same address, looks the array up. This happens in both the directed case and the random phase: the random phase restricts half of its addresses to eight words so that adjacent write and read collide often. The bench judges the result against its reference array after it has applied the write, so the read must see the merged lanes. A second overlap comes from stalls and the asynchronous output enable arriving while a read word is on the bus. The bench checks that the word is held or released without upsetting the pipeline.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_ADV
  } cmdKind_t;

  // strobes handed from control to datapath for one issued beat
  typedef struct packed {
    logic issue;
    logic isWrite;
  } stageCmd_t;

  function automatic logic [1:0] burstLow(input logic [1:0] startBits,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    return interleave ? (startBits ^ beat) : (startBits + beat);
  endfunction

endpackage

// File: rtl/nt_sram_ctrl.sv
module nt_sram_ctrl
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LANES       = 4,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN0,
  input  logic              ce1,
  input  logic              ceN2,
  input  logic              advLoad,
  input  logic              readNotWrite,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              burstInterleave,
  output stageCmd_t         stCmd,
  output logic [ADDR_W-1:0] stAddr,
  output logic [LANES-1:0]  stLanes,
  output logic              pipeEn
);

  localparam int WAKE_W = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES);

  logic [WAKE_W-1:0] wakeCnt;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt;
  logic [1:0]        nextCnt;
  logic              burstActive;
  logic              burstWrite;
  logic              chipSelected;
  logic              inWake;
  cmdKind_t          kind;

  assign chipSelected = !ceN0 && ce1 && !ceN2;
  assign inWake       = (wakeCnt != '0);
  assign nextCnt      = burstCnt + 2'd1;
  assign pipeEn       = !clkEnN && !sleep;

  always_comb begin
    if (advLoad)            kind = burstActive ? CMD_ADV : CMD_NONE;
    else if (!chipSelected) kind = CMD_NONE;
    else if (readNotWrite)  kind = CMD_READ;
    else if (inWake)        kind = CMD_NONE;
    else                    kind = CMD_WRITE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCnt     <= '0;
      baseAddr    <= '0;
      burstCnt    <= 2'd0;
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      stCmd       <= '0;
      stAddr      <= '0;
      stLanes     <= '0;
    end else if (sleep) begin
      wakeCnt     <= WAKE_LOAD;
      burstActive <= 1'b0;
      stCmd       <= '0;
    end else if (!clkEnN) begin
      if (inWake) wakeCnt <= wakeCnt - 1'b1;
      stLanes <= ~byteWeN;
      unique case (kind)
        CMD_READ, CMD_WRITE: begin
          baseAddr    <= addr;
          burstCnt    <= 2'd0;
          burstActive <= 1'b1;
          burstWrite  <= (kind == CMD_WRITE);
          stCmd       <= '{issue: 1'b1, isWrite: (kind == CMD_WRITE)};
          stAddr      <= addr;
        end
        CMD_ADV: begin
          burstCnt <= nextCnt;
          stCmd    <= '{issue: 1'b1, isWrite: burstWrite};
          stAddr   <= {baseAddr[ADDR_W-1:2],
                       burstLow(baseAddr[1:0], nextCnt, burstInterleave)};
        end
        default: begin
          burstActive <= 1'b0;
          stCmd       <= '0;
        end
      endcase
    end
  end

  // a deselecting load issues nothing
  p_desel_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !clkEnN && !advLoad && !chipSelected) |=> !stCmd.issue);

  // an advance keeps the page and the direction of the open burst
  p_adv_page_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !clkEnN && advLoad && burstActive) |=>
      (stCmd.issue && stCmd.isWrite == $past(burstWrite) &&
       stAddr[ADDR_W-1:2] == $past(baseAddr[ADDR_W-1:2])));

  // no write leaves the control during the recovery window
  p_wake_nowrite_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !clkEnN && inWake) |=> !(stCmd.issue && stCmd.isWrite));

  // masked edge leaves command state untouched
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !sleep) |=> ($stable(stAddr) && $stable(burstCnt) && $stable(stCmd)));

endmodule

// File: rtl/nt_sram_datapath.sv
module nt_sram_datapath
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pipeEn,
  input  logic                    sleep,
  input  stageCmd_t               stCmd,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [LANES-1:0]        stLanes,
  input  logic [LANES*LANE_W-1:0] busIn,
  output logic [LANES*LANE_W-1:0] outWord,
  output logic                    driveEn
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrLanes;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdWord;
  logic              stIsRead;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] =
      wrLanes[g] ? busIn[g*LANE_W +: LANE_W] : memArr[wrAddr][g*LANE_W +: LANE_W];
  end

  // a read that meets the commit of its own address sees the new lanes
  assign rdWord   = (wrValid && wrAddr == stAddr) ? mergedWord : memArr[stAddr];
  assign stIsRead = stCmd.issue && !stCmd.isWrite;

  always_ff @(posedge clk) begin
    if (pipeEn && wrValid) memArr[wrAddr] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrLanes <= '0;
      driveEn <= 1'b0;
      outWord <= '0;
    end else if (sleep) begin
      wrValid <= 1'b0;
      driveEn <= 1'b0;
    end else if (pipeEn) begin
      wrValid <= stCmd.issue && stCmd.isWrite;
      wrAddr  <= stAddr;
      wrLanes <= stLanes;
      driveEn <= stIsRead;
      if (stIsRead) outWord <= rdWord;
    end
  end

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && stCmd.issue && !stCmd.isWrite) |=> driveEn);

  p_sleep_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (!driveEn && !wrValid));

  p_stall_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeEn && !sleep) |=> ($stable(outWord) && $stable(driveEn)));

endmodule

// File: rtl/nt_burst_sram.sv
module nt_burst_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LANES       = 4,
  parameter int LANE_W      = 9,
  parameter int WAKE_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ceN0,
  input  logic                    ce1,
  input  logic                    ceN2,
  input  logic                    advLoad,
  input  logic                    readNotWrite,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outEnN,
  input  logic                    burstInterleave,
  input  logic                    sleep,
  inout  wire  [LANES*LANE_W-1:0] dataBus
);

  localparam int DATA_W = LANES * LANE_W;

  stageCmd_t         stCmd;
  logic [ADDR_W-1:0] stAddr;
  logic [LANES-1:0]  stLanes;
  logic              pipeEn;
  logic [DATA_W-1:0] outWord;
  logic              driveEn;
  logic              busDrive;

  nt_sram_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .addr(addr),
    .ceN0(ceN0), .ce1(ce1), .ceN2(ceN2), .advLoad(advLoad),
    .readNotWrite(readNotWrite), .byteWeN(byteWeN),
    .burstInterleave(burstInterleave), .stCmd(stCmd), .stAddr(stAddr),
    .stLanes(stLanes), .pipeEn(pipeEn)
  );

  nt_sram_datapath #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .sleep(sleep), .stCmd(stCmd),
    .stAddr(stAddr), .stLanes(stLanes), .busIn(dataBus),
    .outWord(outWord), .driveEn(driveEn)
  );

  assign busDrive = driveEn && !outEnN && !sleep;
  assign dataBus  = busDrive ? outWord : {DATA_W{1'bz}};

endmodule

// File: tb/tb_nt_burst_sram.sv
module tb_nt_burst_sram;

  localparam int WAKE = 4;

  typedef struct packed {
    logic       v;
    logic       w;
    logic       adv;
    logic       il;
    logic [7:0] a;
    logic [3:0] m;
  } benchOp_t;

  logic clk = 1'b0;
  logic rstN, clkEnN, ceN0, ce1, ceN2, advLoad, readNotWrite;
  logic outEnN, burstInterleave, sleep;
  logic [7:0]  addr;
  logic [3:0]  byteWeN;
  logic        hostDrive = 1'b0;
  logic [35:0] hostData = '0;
  wire  [35:0] dataBus;

  assign dataBus = hostDrive ? hostData : {36{1'bz}};

  always #10 clk = ~clk;

  nt_burst_sram #(.WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr), .ceN0(ceN0),
    .ce1(ce1), .ceN2(ceN2), .advLoad(advLoad), .readNotWrite(readNotWrite),
    .byteWeN(byteWeN), .outEnN(outEnN), .burstInterleave(burstInterleave),
    .sleep(sleep), .dataBus(dataBus)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [35:0] refMem [256];
  benchOp_t opNew, opOld, pend, wrOp;
  logic [35:0] wrData;
  logic [7:0]  bBase;
  logic [1:0]  bCnt;
  logic        bAct = 1'b0, bWr = 1'b0;
  int          wakeLeft = 0;
  string       forceTag = "";

  task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                     input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus must be released: bench drives zeros and must read them back
  task automatic probeFloat(input string tag);
    hostData  = '0;
    hostDrive = 1'b1;
    #1;
    chk(dataBus === 36'h0, tag, dataBus, 36'h0);
    hostDrive = 1'b0;
    #1;
  endtask

  function automatic logic [35:0] rnd36();
    return 36'({$urandom, $urandom});
  endfunction

  task automatic slot();
    bit committed = 1'b0;
    logic [7:0] commitA = '0;
    string tag;
    if (wrOp.v) begin
      for (int i = 0; i < 4; i++)
        if (wrOp.m[i]) refMem[wrOp.a][i*9 +: 9] = wrData[i*9 +: 9];
      committed = 1'b1;
      commitA   = wrOp.a;
      wrOp      = '0;
    end
    opOld     = opNew;
    opNew     = pend;
    hostDrive = 1'b0;
    if (opOld.v && opOld.w) begin
      wrData    = rnd36();
      hostData  = wrData;
      hostDrive = 1'b1;
      wrOp      = opOld;
    end else if (opOld.v) begin
      if (forceTag != "")                        tag = forceTag;
      else if (committed && commitA == opOld.a)  tag = "R9";
      else if (opOld.adv)                        tag = opOld.il ? "R4" : "R5";
      else                                       tag = "R2";
      if (($urandom % 4) == 0) begin
        outEnN = 1'b1;
        probeFloat("R7");
        outEnN = 1'b0;
      end
      #1;
      chk(dataBus === refMem[opOld.a], tag, dataBus, refMem[opOld.a]);
    end else begin
      probeFloat("R8");
    end
  endtask

  task automatic step(input logic adv, input logic sel, input logic rd,
                      input logic [7:0] a, input logic [3:0] bwN);
    int r;
    advLoad = adv; readNotWrite = rd; addr = a; byteWeN = bwN; clkEnN = 1'b0;
    r = $urandom % 3;
    ceN0 = sel ? 1'b0 : (r == 0);
    ce1  = sel ? 1'b1 : (r != 1);
    ceN2 = sel ? 1'b0 : (r == 2);
    pend = '0;
    if (!adv) begin
      if (!sel)                     bAct = 1'b0;
      else if (!rd && wakeLeft > 0) bAct = 1'b0;
      else begin
        bBase = a; bCnt = 2'd0; bAct = 1'b1; bWr = !rd;
        pend = '{v: 1'b1, w: !rd, adv: 1'b0, il: burstInterleave, a: a, m: ~bwN};
      end
    end else if (bAct) begin
      bCnt = bCnt + 2'd1;
      pend = '{v: 1'b1, w: bWr, adv: 1'b1, il: burstInterleave,
               a: {bBase[7:2], burstInterleave ? (bBase[1:0] ^ bCnt)
                                               : (bBase[1:0] + bCnt)},
               m: ~bwN};
    end
    if (wakeLeft > 0) wakeLeft--;
    @(posedge clk);
    @(negedge clk);
    slot();
  endtask

  // masked edge: garbage inputs, bus state must hold (R6)
  task automatic stall();
    clkEnN = 1'b1; advLoad = $urandom; addr = $urandom; readNotWrite = $urandom;
    ceN0 = 1'b0; ce1 = 1'b1; ceN2 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (opOld.v && !opOld.w) chk(dataBus === refMem[opOld.a], "R6", dataBus, refMem[opOld.a]);
    else if (!opOld.v)       probeFloat("R6");
    clkEnN = 1'b0;
  endtask

  task automatic desel();
    step(1'b0, 1'b0, 1'b1, 8'h00, 4'hF);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    opNew = '0; opOld = '0; pend = '0; wrOp = '0; wrData = '0;
    bBase = '0; bCnt = '0;
    rstN = 1'b0; clkEnN = 1'b0; ceN0 = 1'b1; ce1 = 1'b0; ceN2 = 1'b1;
    advLoad = 1'b0; readNotWrite = 1'b1; addr = '0; byteWeN = 4'hF;
    outEnN = 1'b0; burstInterleave = 1'b1; sleep = 1'b0;
    repeat (3) @(negedge clk);
    probeFloat("R1");
    rstN = 1'b1;
    desel();

    // fill: interleaved bursts for the lower half, linear for the upper
    for (int b = 0; b < 64; b++) begin
      burstInterleave = (b < 32);
      step(1'b0, 1'b1, 1'b0, 8'(b * 4), 4'h0);
      for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 8'h00, 4'h0);
    end
    burstInterleave = 1'b1;
    desel(); desel();

    // R3: partial lane write, lanes 0 and 2 enabled
    step(1'b0, 1'b1, 1'b0, 8'h40, 4'b1010);
    desel(); desel();
    forceTag = "R3";
    step(1'b0, 1'b1, 1'b1, 8'h40, 4'hF);
    desel();
    forceTag = "";
    desel();

    // R9: read right behind a masked write to the same word
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 1'b0, 8'h55 + 8'(k), 4'(k * 5 + 1));
      step(1'b0, 1'b1, 1'b1, 8'h55 + 8'(k), 4'hF);
      desel(); desel();
    end

    // R5: linear write burst wrapping past four beats, then read it back
    burstInterleave = 1'b0;
    step(1'b0, 1'b1, 1'b0, 8'h7E, 4'h0);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1, 8'h00, 4'h0);
    step(1'b0, 1'b1, 1'b1, 8'h7E, 4'hF);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 4'h0);
    desel(); desel();

    // R4: interleaved read burst from an odd start
    burstInterleave = 1'b1;
    step(1'b0, 1'b1, 1'b1, 8'h63, 4'hF);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 8'hFF, 4'h0);
    desel(); desel();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if ((n % 500) == 0) burstInterleave = $urandom;
      if (($urandom % 20) == 0) stall();
      step(($urandom % 10) < 4, ($urandom % 8) != 0, $urandom,
           ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom),
           (($urandom % 4) == 0) ? 4'h0 : 4'($urandom));
    end
    desel(); desel();

    // R10: sleep while a read is on the bus
    step(1'b0, 1'b1, 1'b1, 8'h30, 4'hF);
    desel();
    sleep = 1'b1;
    #1;
    probeFloat("R10");
    for (int k = 0; k < 6; k++) begin
      advLoad = 1'b0; ceN0 = 1'b0; ce1 = 1'b1; ceN2 = 1'b0; readNotWrite = 1'b0;
      addr = (k == 0) ? 8'h30 : 8'($urandom); byteWeN = 4'h0;
      hostData = rnd36(); hostDrive = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    hostDrive = 1'b0;
    probeFloat("R10");
    opNew = '0; opOld = '0; wrOp = '0; bAct = 1'b0;
    sleep = 1'b0;
    wakeLeft = WAKE;

    // R11: write inside the recovery window is dropped, read still works
    step(1'b0, 1'b1, 1'b0, 8'h30, 4'h0);
    step(1'b0, 1'b1, 1'b1, 8'h30, 4'hF);
    forceTag = "R11";
    desel();
    forceTag = "";
    while (wakeLeft > 0) desel();
    step(1'b0, 1'b1, 1'b0, 8'h30, 4'h0);
    desel(); desel();
    forceTag = "R11";
    step(1'b0, 1'b1, 1'b1, 8'h30, 4'hF);
    desel();
    forceTag = "";
    desel();

    for (int n = 0; n < 500; n++) begin
      if (($urandom % 20) == 0) stall();
      step(($urandom % 10) < 4, ($urandom % 8) != 0, $urandom,
           8'($urandom), 4'($urandom));
    end
    desel(); desel();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule